// File: doc/BRIEF.md
# Coprocessor Interface Register Protocol Controller

This block sits on the slave side of a small register window. A host processor uses the window to pass instructions to a floating-point coprocessor. The host writes a 16-bit command word or a 16-bit condition predicate. It reads a 16-bit response register to learn the next step of the dialog. It moves operands through a 32-bit operand register. The block checks every access against the point the dialog has reached. A legal access either starts work or is held in a single waiting slot. An access at the wrong point puts a violation code in the response register, raises a sticky error flag, and throws the written word away.

The arithmetic execution unit and the condition evaluator sit outside the block. A started instruction is reported by a one-cycle `exu_start` pulse that carries the command word. The execution unit ends it with `exu_done`. Condition evaluation is combinational: the block presents the 6-bit predicate on `cond_pred` and samples `cond_true` in the same cycle.

Operand traffic is allowed only inside a transfer window. The window is a down-counter of 32-bit transfers. Each operand access uses one slot, and any operand access made while the counter is zero is a violation. The counter is loaded by a memory-operand or single-register command, by a register-select read after a multi-register command, by a save read, or by a restore write of an idle or busy format word. Multi-long-word operands are moved as a run of 32-bit accesses and are aligned to the most significant byte.

Top module: `cir_protocol_ctrl`

## Requirements
- R1: After reset the response register reads 0x0200 (plain null code), `err` is 0, `exu_start` is 0, and the transfer window is closed.
- R2: A command write to offset 0x0A while idle gives a one-cycle `exu_start` in the next cycle, with `exu_word` set to the command. For class bits [15:14]=00 the response becomes 0x0202 (null, run-in-progress bit [1] set).
- R3: A command of class 01 sets the response to 0x9000|(n<<4), and class 10 sets it to 0x8C10, where n = word[2:0]+1. Each opens a window of n or 1 long-word transfers. Every command starts an initial phase that lasts until the host reads the response at offset 0x00.
- R4: A command written while an instruction runs and the waiting slot is empty is held, and the response becomes 0x8202 (CA bit [15]=1, IA bit [1]=1). On `exu_done` the held command is issued automatically, as if it had just been written while idle.
- R5: A condition write to offset 0x0E while idle drives `cond_pred` with data[5:0]. The response becomes 0x0200 with bit [0] equal to `cond_true`. Writes stay blocked until the host reads the response.
- R6: A condition written while an instruction runs is held, and the response becomes 0x8202. On `exu_done` it is evaluated and the response is set as in R5.
- R7: A command or condition write is a violation in three cases: during the initial phase, before the response read that follows a condition result, or while busy with the slot full. A violation sets `err`, sets the response to 0x3F00, and discards the word: no start and nothing held.
- R8: An operand access to offset 0x10 (read or write) inside an open window uses one transfer. A write appears on `opnd_wdata` with a one-cycle `opnd_wstb` in the next cycle. A read returns `opnd_rdata`. An operand access with no transfers left is a violation.
- R9: A command of class 11 sets the response to 0x8400|(n<<4). A following read of offset 0x14 returns a mask with the low n bits set and opens a window of n transfers. A read of 0x14 when no such command is armed is a violation.
- R10: A read of offset 0x04 returns 0x1000|IDLE_LEN when idle, or 0x2000|BUSY_LEN while an instruction runs, and opens a window of that length. A write to offset 0x06 with data[15:12]=1 opens IDLE_LEN transfers, with 2 it opens BUSY_LEN, and any other value opens none.
- R11: `err` stays set until `err_ack` is pulsed in a cycle with no new violation.
- R12: `exu_done` with nothing held returns the block to idle, and the response becomes 0x0200.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | AW | Register byte offset |
| wdata | input | 32 | Host write data |
| rdata | output | 32 | Host read data (combinational) |
| err_ack | input | 1 | Clears the sticky error flag |
| err | output | 1 | Sticky protocol-violation flag |
| exu_start | output | 1 | One-cycle instruction start pulse |
| exu_word | output | 16 | Command word being started |
| exu_done | input | 1 | Execution unit finished the running instruction |
| cond_pred | output | 6 | Predicate presented to the evaluator |
| cond_true | input | 1 | Evaluator result for `cond_pred` |
| opnd_wstb | output | 1 | Operand write strobe to the execution unit |
| opnd_wdata | output | 32 | Last legally written operand |
| opnd_rdata | input | 32 | Operand supplied for host reads |

## Verification
Host reads are combinational, so the bench samples read data one time unit after it drives the read, well before the next edge. Register results come one edge after the access: the response code, the error flag, `exu_start`, `exu_word` and `opnd_wstb`. The bench drives each access for a single cycle starting at a falling edge, and checks these results at the next falling edge. The pulse outputs are checked again one cycle later to confirm they have dropped. A held word is issued by the edge that samples `exu_done`, so the response and start checks after a done pulse follow the same one-edge rule.

// File: rtl/cir_protocol_ctrl.sv
module cir_protocol_ctrl #(
  parameter int AW       = 5,
  parameter int CW       = 4,
  parameter int IDLE_LEN = 3,
  parameter int BUSY_LEN = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  input  logic          err_ack,
  output logic          err,
  output logic          exu_start,
  output logic [15:0]   exu_word,
  input  logic          exu_done,
  output logic [5:0]    cond_pred,
  input  logic          cond_true,
  output logic          opnd_wstb,
  output logic [31:0]   opnd_wdata,
  input  logic [31:0]   opnd_rdata
);

  localparam logic [AW-1:0] A_RSP = AW'(5'h00);
  localparam logic [AW-1:0] A_SAV = AW'(5'h04);
  localparam logic [AW-1:0] A_RES = AW'(5'h06);
  localparam logic [AW-1:0] A_CMD = AW'(5'h0A);
  localparam logic [AW-1:0] A_CND = AW'(5'h0E);
  localparam logic [AW-1:0] A_OPD = AW'(5'h10);
  localparam logic [AW-1:0] A_SEL = AW'(5'h14);

  localparam logic [15:0] P_IDLE  = 16'h0200;
  localparam logic [15:0] P_RUN   = 16'h0202;
  localparam logic [15:0] P_BUSY  = 16'h8202;
  localparam logic [15:0] P_PROTO = 16'h3F00;
  localparam logic [15:0] F_IDLE  = 16'h1000 | 16'(IDLE_LEN);
  localparam logic [15:0] F_BUSY  = 16'h2000 | 16'(BUSY_LEN);

  logic [15:0]   resp;
  logic          run, gen_init, cond_wait;
  logic          pend_v, pend_k;
  logic [15:0]   pend_w;
  logic [CW-1:0] cnt, sel_n;

  logic hit_cmd, hit_cnd, hit_op, hit_rsp, hit_sav, hit_res, hit_sel;
  logic finishing, issue, busy, word_ok, viol, go_cmd, go_cnd, park;
  logic start_cmd, eval;
  logic [15:0] start_word;
  logic [CW-1:0] start_n;
  logic [15:0] sel_mask;

  function automatic logic [15:0] first_prim(input logic [15:0] w);
    logic [3:0] n;
    n = {1'b0, w[2:0]} + 4'd1;
    case (w[15:14])
      2'b00:   return P_RUN;
      2'b01:   return {8'h90, n, 4'h0};
      2'b10:   return 16'h8C10;
      default: return {8'h84, n, 4'h0};
    endcase
  endfunction

  assign hit_cmd = wr_en && addr == A_CMD;
  assign hit_cnd = wr_en && addr == A_CND;
  assign hit_op  = (wr_en || rd_en) && addr == A_OPD;
  assign hit_rsp = rd_en && addr == A_RSP;
  assign hit_sav = rd_en && addr == A_SAV;
  assign hit_res = wr_en && addr == A_RES;
  assign hit_sel = rd_en && addr == A_SEL;

  assign finishing = run && exu_done;
  assign issue     = finishing && pend_v;
  assign busy      = run && !(finishing && !pend_v);
  assign word_ok   = !gen_init && !cond_wait && !(busy && pend_v);
  assign viol      = ((hit_cmd || hit_cnd) && !word_ok)
                   || (hit_op && cnt == '0) || (hit_sel && sel_n == '0);
  assign go_cmd    = hit_cmd && word_ok && !busy;
  assign go_cnd    = hit_cnd && word_ok && !busy;
  assign park      = (hit_cmd || hit_cnd) && word_ok && busy;

  assign start_cmd  = go_cmd || (issue && !pend_k);
  assign start_word = go_cmd ? wdata[15:0] : pend_w;
  assign start_n    = CW'({1'b0, start_word[2:0]}) + CW'(1);
  assign eval       = go_cnd || (issue && pend_k);
  assign cond_pred  = issue ? pend_w[5:0] : wdata[5:0];
  assign sel_mask   = 16'((17'd1 << sel_n) - 17'd1);

  always_comb begin
    rdata = 32'h0;
    case (addr)
      A_RSP:   rdata = {16'h0, resp};
      A_SAV:   rdata = {16'h0, run ? F_BUSY : F_IDLE};
      A_OPD:   rdata = opnd_rdata;
      A_SEL:   rdata = {16'h0, sel_mask};
      default: rdata = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp       <= P_IDLE;
      err        <= 1'b0;
      run        <= 1'b0;
      gen_init   <= 1'b0;
      cond_wait  <= 1'b0;
      pend_v     <= 1'b0;
      pend_k     <= 1'b0;
      pend_w     <= '0;
      cnt        <= '0;
      sel_n      <= '0;
      exu_start  <= 1'b0;
      exu_word   <= '0;
      opnd_wstb  <= 1'b0;
      opnd_wdata <= '0;
    end else begin
      exu_start <= start_cmd;
      if (start_cmd) exu_word <= start_word;
      opnd_wstb <= hit_op && wr_en && cnt != '0;
      if (hit_op && wr_en && cnt != '0) opnd_wdata <= wdata;

      if (hit_rsp) begin
        gen_init  <= 1'b0;
        cond_wait <= 1'b0;
      end

      if (finishing) begin
        run <= 1'b0;
        if (!pend_v) resp <= P_IDLE;
      end
      if (issue) pend_v <= 1'b0;

      if (hit_op && cnt != '0) cnt <= cnt - CW'(1);
      if (hit_sav) cnt <= run ? CW'(BUSY_LEN) : CW'(IDLE_LEN);
      if (hit_res) begin
        if (wdata[15:12] == 4'h1) cnt <= CW'(IDLE_LEN);
        else if (wdata[15:12] == 4'h2) cnt <= CW'(BUSY_LEN);
      end
      if (hit_sel && sel_n != '0) begin
        cnt   <= sel_n;
        sel_n <= '0;
      end

      if (start_cmd) begin
        run      <= 1'b1;
        gen_init <= 1'b1;
        resp     <= first_prim(start_word);
        case (start_word[15:14])
          2'b01:   cnt <= start_n;
          2'b10:   cnt <= CW'(1);
          2'b11:   sel_n <= start_n;
          default: ;
        endcase
      end

      if (eval) begin
        resp      <= P_IDLE | {15'h0, cond_true};
        cond_wait <= 1'b1;
      end

      if (park) begin
        pend_v <= 1'b1;
        pend_k <= hit_cnd;
        pend_w <= wdata[15:0];
        resp   <= P_BUSY;
      end

      if (err_ack) err <= 1'b0;
      if (viol) begin
        err  <= 1'b1;
        resp <= P_PROTO;
      end
    end
  end

  AST_START_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    exu_start |-> run); // R2
  AST_PARK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    park |=> (pend_v && resp == P_BUSY)); // R4
  AST_PEND_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v && !issue) |=> (pend_v && $stable(pend_w))); // R4
  AST_COND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_wait && !hit_rsp) |=> cond_wait); // R5
  AST_VIOL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> (err && resp == P_PROTO)); // R7
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_op && cnt != '0 && !start_cmd) |=> cnt == $past(cnt) - CW'(1)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !err_ack) |=> err); // R11

endmodule

// File: tb/cir_protocol_ctrl_test.sv
module cir_protocol_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, err_ack = 1'b0, exu_done = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, opnd_wdata;
  logic [31:0] opnd_rdata = 32'hC0DE_1234;
  logic        err, exu_start, opnd_wstb, cond_true;
  logic [15:0] exu_word;
  logic [5:0]  cond_pred;
  int checks = 0, errors = 0;
  bit  done_flag = 0;

  always #5 clk = ~clk;
  assign cond_true = ^cond_pred;

  cir_protocol_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .err_ack(err_ack), .err(err),
    .exu_start(exu_start), .exu_word(exu_word), .exu_done(exu_done),
    .cond_pred(cond_pred), .cond_true(cond_true), .opnd_wstb(opnd_wstb),
    .opnd_wdata(opnd_wdata), .opnd_rdata(opnd_rdata));

  function automatic logic [15:0] exp_first(input logic [15:0] w);
    logic [3:0] n = {1'b0, w[2:0]} + 4'd1;
    case (w[15:14])
      2'b00:   return 16'h0202;
      2'b01:   return {8'h90, n, 4'h0};
      2'b10:   return 16'h8C10;
      default: return {8'h84, n, 4'h0};
    endcase
  endfunction

  function automatic logic [15:0] exp_cond(input logic [5:0] p);
    return 16'h0200 | {15'h0, ^p};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); err_ack = 1'b1;
    @(negedge clk); err_ack = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk); exu_done = 1'b1;
    @(negedge clk); exu_done = 1'b0;
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
    end
  end

  initial begin
    logic [31:0] d;
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 err", {31'h0, err}, 32'h0);
    chk("R1 start", {31'h0, exu_start}, 32'h0);
    rd(5'h00, d); chk("R1 resp", d, 32'h0200);

    // R2 register-class command while idle
    wr(5'h0A, 32'h0005);
    chk("R2 start", {31'h0, exu_start}, 32'h1);
    chk("R2 word", {16'h0, exu_word}, 32'h0005);
    @(negedge clk); chk("R2 pulse drop", {31'h0, exu_start}, 32'h0);
    rd(5'h00, d); chk("R2 resp", d, 32'h0202);
    done_pulse();
    rd(5'h00, d); chk("R12 idle resp", d, 32'h0200);

    // R5 conditions while idle, true and false
    wr(5'h0E, 32'h07); rd(5'h00, d); chk("R5 true", d, 32'h0201);
    wr(5'h0E, 32'h03); rd(5'h00, d); chk("R5 false", d, 32'h0200);

    // R7 condition before previous result read
    wr(5'h0E, 32'h01);
    wr(5'h0E, 32'h02);
    chk("R7 err", {31'h0, err}, 32'h1);
    rd(5'h00, d); chk("R7 proto", d, 32'h3F00);
    chk("R11 sticky", {31'h0, err}, 32'h1);
    ack(); chk("R11 ack", {31'h0, err}, 32'h0);

    // R3 memory-operand command, gen-init lock, window of 4
    wr(5'h0A, 32'h4003);
    chk("R3 start", {31'h0, exu_start}, 32'h1);
    wr(5'h0E, 32'h01);
    chk("R7 init err", {31'h0, err}, 32'h1);
    chk("R7 no start", {31'h0, exu_start}, 32'h0);
    rd(5'h00, d); chk("R7 proto", d, 32'h3F00);
    ack();
    for (int i = 0; i < 4; i++) begin
      wr(5'h10, 32'h1111_0000 + i);
      chk("R8 wstb", {31'h0, opnd_wstb}, 32'h1);
      chk("R8 wdata", opnd_wdata, 32'h1111_0000 + i);
      chk("R8 legal", {31'h0, err}, 32'h0);
    end
    wr(5'h10, 32'hDEAD);
    chk("R8 over err", {31'h0, err}, 32'h1);
    chk("R8 no wstb", {31'h0, opnd_wstb}, 32'h0);
    ack(); done_pulse();
    rd(5'h00, d); chk("R12 resp", d, 32'h0200);
    rd(5'h10, d); chk("R8 closed err", {31'h0, err}, 32'h1);
    ack();

    // R4 command while busy, held then auto-issued; full slot violation
    wr(5'h0A, 32'h0001); rd(5'h00, d);
    wr(5'h0A, 32'h4001);
    chk("R4 no start", {31'h0, exu_start}, 32'h0);
    rd(5'h00, d); chk("R4 busy resp", d, 32'h8202);
    wr(5'h0A, 32'h0007);
    chk("R7 full err", {31'h0, err}, 32'h1);
    ack();
    done_pulse();
    chk("R4 issued", {31'h0, exu_start}, 32'h1);
    chk("R4 word", {16'h0, exu_word}, 32'h4001);
    rd(5'h00, d); chk("R4 resp", d, 32'h9020);
    rd(5'h10, d); chk("R8 read", d, 32'hC0DE_1234);
    rd(5'h10, d); chk("R8 read err", {31'h0, err}, 32'h0);
    done_pulse();

    // R6 condition while busy
    wr(5'h0A, 32'h0002); rd(5'h00, d);
    wr(5'h0E, 32'h04);
    rd(5'h00, d); chk("R6 busy resp", d, 32'h8202);
    done_pulse();
    rd(5'h00, d); chk("R6 evaluated", d, 32'h0201);

    // R9 multi-register transfer
    rd(5'h14, d); chk("R9 unarmed err", {31'h0, err}, 32'h1);
    ack();
    wr(5'h0A, 32'hC002); rd(5'h00, d); chk("R9 resp", d, 32'h8430);
    rd(5'h10, d); chk("R9 early err", {31'h0, err}, 32'h1);
    ack();
    rd(5'h14, d); chk("R9 mask", d, 32'h0007);
    for (int i = 0; i < 3; i++) wr(5'h10, i);
    chk("R9 window", {31'h0, err}, 32'h0);
    done_pulse();

    // R10 save and restore windows
    rd(5'h04, d); chk("R10 idle fmt", d, 32'h1003);
    for (int i = 0; i < 3; i++) rd(5'h10, d);
    chk("R10 idle win", {31'h0, err}, 32'h0);
    rd(5'h10, d); chk("R10 idle end", {31'h0, err}, 32'h1);
    ack();
    wr(5'h06, 32'h2000);
    for (int i = 0; i < 6; i++) wr(5'h10, i);
    chk("R10 busy win", {31'h0, err}, 32'h0);
    wr(5'h06, 32'h0000); wr(5'h10, 0);
    chk("R10 null fmt", {31'h0, err}, 32'h1);
    ack();
    wr(5'h0A, 32'h0000); rd(5'h00, d);
    rd(5'h04, d); chk("R10 busy fmt", d, 32'h2006);
    done_pulse();
    for (int i = 0; i < 6; i++) rd(5'h10, d);
    chk("R10 busy len", {31'h0, err}, 32'h0);

    // random phase
    for (int k = 0; k < 30; k++) begin
      logic [5:0]  p = 6'($urandom());
      logic [15:0] w = 16'h4000 | 16'($urandom_range(7, 0));
      wr(5'h0E, {26'h0, p}); rd(5'h00, d);
      chk("R5 random", d, {16'h0, exp_cond(p)});
      wr(5'h0A, {16'h0, w}); rd(5'h00, d);
      chk("R3 random", d, {16'h0, exp_first(w)});
      for (int i = 0; i <= int'(w[2:0]); i++) begin
        logic [31:0] v = $urandom();
        wr(5'h10, v);
        chk("R8 random data", opnd_wdata, v);
      end
      chk("R8 random legal", {31'h0, err}, 32'h0);
      wr(5'h10, 0);
      chk("R8 random over", {31'h0, err}, 32'h1);
      ack(); done_pulse();
    end

    done_flag = 1;
    report();
  end
endmodule